// File: doc/BRIEF.md
# Recursive Quadrature Sine Oscillator

This block produces an endless, in-order stream of sine and cosine samples in signed fixed-point form. It holds two state registers and advances them with a coupled recursion. Both feedback products use a power-of-two coefficient, so each product is an arithmetic right shift and no multiplier or lookup table is needed. The cosine update takes the sine value computed in the same step instead of the previous one. This keeps the amplitude bounded over long runs and adds only a small distortion to the waveform.

The caller picks the frequency with a small shift input. The block latches that input only when it is reset or restarted. After that, each cycle with the step enable high advances the phase by roughly 2^-shift radians. A valid strobe marks every cycle in which a new sample pair is on the outputs. The block cannot jump to an arbitrary phase. A restart is the only way back to the starting point.

Top module: `quad_osc`

## Requirements
- R1: A reset or restart loads the sine output with 0x7FFF (+1.0 in Q1.15), loads the cosine output with zero and drives sample_vld low in the following cycle.
- R2: On each enabled step the new sine equals the old sine minus the old cosine arithmetically shifted right by the latched shift k.
- R3: On the same step the new cosine equals the old cosine plus the newly computed sine (not the old one) arithmetically shifted right by k.
- R4: Every sum saturates to 32767 or -32768 instead of wrapping. For example, with k=1 the third step from restart yields cosine 32767.
- R5: Each enabled step updates both outputs at the next clock edge and raises sample_vld for exactly that cycle, one strobe per step.
- R6: With step_en low and no restart, both outputs hold their values and sample_vld stays low.
- R7: shift_amt is latched only at reset or restart. A change during a run has no effect on the samples.
- R8: A shift_amt of 0 is latched as 1.
- R9: restart takes priority over step_en in the same cycle. The result is the load values of R1 with sample_vld low.
- R10: With k=6 the sine peaks lie within 3% of full scale in both polarities. The distance between successive falling zero crossings is 2π·64 ≈ 402 samples, within ±4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| restart | input | 1 | Synchronous restart to the initial phase; latches shift_amt |
| step_en | input | 1 | Advance the recursion by one step |
| shift_amt | input | SHIFT_W | Frequency coefficient exponent, k = 2^-shift_amt |
| sin_out | output | SAMPLE_W | Sine sample, signed Q1.15 |
| cos_out | output | SAMPLE_W | Cosine sample, signed Q1.15 |
| sample_vld | output | 1 | High for one cycle per enabled step |

## Verification
The state registers drive the outputs directly. A step enabled in cycle N therefore shows its samples and its strobe on the outputs after edge N+1, and a restart shows the load values after that same edge. The driver drives inputs on falling edges and pushes the expected pair into a queue on the same edge. The monitor pops one entry per strobe on the next falling edge. Hold, restart and saturation checks sample one falling edge after the stimulus edge. The period and peak checks run over a 1000-step window.

// File: rtl/osc_pkg.sv
`timescale 1ns/1ps
package osc_pkg;
   localparam int unsigned OSC_SAMPLE_W_DEF = 16;
   localparam int unsigned OSC_SHIFT_W_DEF  = 4;

   // Latched coefficient exponent: zero is promoted to one.
   function automatic int unsigned osc_fix_shift(input int unsigned raw);
      return (raw == 0) ? 1 : raw;
   endfunction
endpackage

// File: rtl/osc_ashift.sv
`timescale 1ns/1ps
module osc_ashift #(
   parameter int unsigned W  = 16,
   parameter int unsigned SW = 4
) (
   input  logic signed [W-1:0]  din,
   input  logic        [SW-1:0] sh,
   output logic signed [W-1:0]  dout
);
   initial assert (SW < 32 && W >= 4) else $error("osc_ashift: bad widths");
   assign dout = din >>> sh;
endmodule

// File: rtl/osc_sat_add.sv
`timescale 1ns/1ps
module osc_sat_add #(
   parameter int unsigned W        = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic signed [W-1:0] a,
   input  logic signed [W-1:0] b,
   input  logic                sub,
   output logic signed [W-1:0] sum
);
   localparam logic signed [W-1:0] MAX_CODE = {1'b0, {(W-1){1'b1}}};
   localparam logic signed [W-1:0] MIN_CODE = {1'b1, {(W-1){1'b0}}};

   logic signed [W:0] wide;
   assign wide = sub ? ({a[W-1], a} - {b[W-1], b}) : ({a[W-1], a} + {b[W-1], b});

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (wide[W] != wide[W-1]) sum = wide[W] ? MIN_CODE : MAX_CODE;
            else                      sum = wide[W-1:0];
         end
      end else begin : g_wrap
         assign sum = wide[W-1:0];
      end
   endgenerate
endmodule

// File: rtl/quad_osc.sv
`timescale 1ns/1ps
module quad_osc #(
   parameter int unsigned SAMPLE_W = osc_pkg::OSC_SAMPLE_W_DEF,
   parameter int unsigned SHIFT_W  = osc_pkg::OSC_SHIFT_W_DEF,
   parameter bit          SATURATE = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       restart,
   input  logic                       step_en,
   input  logic [SHIFT_W-1:0]         shift_amt,
   output logic signed [SAMPLE_W-1:0] sin_out,
   output logic signed [SAMPLE_W-1:0] cos_out,
   output logic                       sample_vld
);
   localparam logic signed [SAMPLE_W-1:0] ONE_CODE = {1'b0, {(SAMPLE_W-1){1'b1}}};

   initial assert (SAMPLE_W >= 4 && SAMPLE_W <= 32) else $error("quad_osc: SAMPLE_W out of range");
   initial assert (SHIFT_W >= 1 && SHIFT_W <= 5) else $error("quad_osc: SHIFT_W out of range");

   logic [SHIFT_W-1:0]         k_q;
   logic [SHIFT_W-1:0]         k_load;
   logic signed [SAMPLE_W-1:0] cos_scaled, sin_next, sin_scaled, cos_next;

   assign k_load = SHIFT_W'(osc_pkg::osc_fix_shift(32'(shift_amt)));

   osc_ashift #(.W(SAMPLE_W), .SW(SHIFT_W)) u_shift_cos (
      .din(cos_out), .sh(k_q), .dout(cos_scaled));

   osc_sat_add #(.W(SAMPLE_W), .SATURATE(SATURATE)) u_add_sin (
      .a(sin_out), .b(cos_scaled), .sub(1'b1), .sum(sin_next));

   // Cosine path is fed by the freshly computed sine.
   osc_ashift #(.W(SAMPLE_W), .SW(SHIFT_W)) u_shift_sin (
      .din(sin_next), .sh(k_q), .dout(sin_scaled));

   osc_sat_add #(.W(SAMPLE_W), .SATURATE(SATURATE)) u_add_cos (
      .a(cos_out), .b(sin_scaled), .sub(1'b0), .sum(cos_next));

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         sin_out    <= ONE_CODE;
         cos_out    <= '0;
         sample_vld <= 1'b0;
         k_q        <= k_load;
      end else if (step_en) begin
         sin_out    <= sin_next;
         cos_out    <= cos_next;
         sample_vld <= 1'b1;
      end else begin
         sample_vld <= 1'b0;
      end
   end
endmodule

// File: rtl/quad_osc_chk.sv
`timescale 1ns/1ps
module quad_osc_chk #(
   parameter int unsigned SAMPLE_W = 16,
   parameter int unsigned SHIFT_W  = 4
) (
   input logic                       clk,
   input logic                       rst,
   input logic                       restart,
   input logic                       step_en,
   input logic signed [SAMPLE_W-1:0] sin_out,
   input logic signed [SAMPLE_W-1:0] cos_out,
   input logic                       sample_vld,
   input logic [SHIFT_W-1:0]         k_q
);
   localparam longint MAXV = (64'sd1 <<< (SAMPLE_W-1)) - 1;
   localparam longint MINV = -(64'sd1 <<< (SAMPLE_W-1));

   function automatic longint clip(input longint v);
      return (v > MAXV) ? MAXV : ((v < MINV) ? MINV : v);
   endfunction

   function automatic longint exp_sin(input longint s, input longint c, input int unsigned k);
      return clip(s - (c >>> k));
   endfunction

   function automatic longint exp_cos(input longint c, input longint s_new, input int unsigned k);
      return clip(c + (s_new >>> k));
   endfunction

   // R1
   p_restart_load_r1: assert property (@(posedge clk) disable iff (rst)
      restart |=> (longint'(sin_out) == MAXV && cos_out == '0 && !sample_vld));

   // R2
   p_sin_step_r2: assert property (@(posedge clk) disable iff (rst)
      (step_en && !restart) |=>
         longint'(sin_out) == exp_sin(longint'($past(sin_out)), longint'($past(cos_out)), 32'($past(k_q))));

   // R3
   p_cos_step_r3: assert property (@(posedge clk) disable iff (rst)
      (step_en && !restart) |=>
         longint'(cos_out) == exp_cos(longint'($past(cos_out)), longint'(sin_out), 32'($past(k_q))));

   // R5
   p_step_strobe_r5: assert property (@(posedge clk) disable iff (rst)
      (step_en && !restart) |=> sample_vld);

   // R6
   p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (!step_en && !restart) |=> ($stable(sin_out) && $stable(cos_out) && !sample_vld));

   // R7
   p_shift_kept_r7: assert property (@(posedge clk) disable iff (rst)
      !restart |=> $stable(k_q));

   // R8
   p_shift_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
      !restart |=> (k_q != '0));
endmodule

bind quad_osc quad_osc_chk #(.SAMPLE_W(SAMPLE_W), .SHIFT_W(SHIFT_W)) u_chk (
   .clk(clk), .rst(rst), .restart(restart), .step_en(step_en),
   .sin_out(sin_out), .cos_out(cos_out), .sample_vld(sample_vld), .k_q(k_q));

// File: tb/tb_quad_osc.sv
`timescale 1ns/1ps
module tb_quad_osc;
   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              restart = 1'b0;
   logic              step_en = 1'b0;
   logic [3:0]        shift_amt = 4'd1;
   logic signed [15:0] sin_out, cos_out;
   logic              sample_vld;

   int n_checks = 0;
   int n_errors = 0;

   typedef struct { int s; int c; } pair_t;
   pair_t exp_q[$];

   int m_s, m_c, m_k;

   bit meas_on = 1'b0;
   int meas_idx, peak_hi, peak_lo, prev_s, x_first, x_second;

   always #2.5 clk = ~clk;

   quad_osc dut (
      .clk(clk), .rst(rst), .restart(restart), .step_en(step_en),
      .shift_amt(shift_amt), .sin_out(sin_out), .cos_out(cos_out),
      .sample_vld(sample_vld));

   function automatic int clip(input int v);
      return (v > 32767) ? 32767 : ((v < -32768) ? -32768 : v);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp_v);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   // Monitor: one expected pair per strobe
   always @(negedge clk) begin
      if (!rst && sample_vld) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R5 unexpected strobe", 1, 0);
         end else begin
            pair_t e;
            e = exp_q.pop_front();
            check(int'(sin_out) == e.s, "R2 sine sample", int'(sin_out), e.s);
            check(int'(cos_out) == e.c, "R3 cosine sample", int'(cos_out), e.c);
         end
         if (meas_on) begin
            if (int'(sin_out) > peak_hi) peak_hi = int'(sin_out);
            if (int'(sin_out) < peak_lo) peak_lo = int'(sin_out);
            if (prev_s >= 0 && int'(sin_out) < 0) begin
               if (x_first < 0) x_first = meas_idx;
               else if (x_second < 0) x_second = meas_idx;
            end
            prev_s = int'(sin_out);
            meas_idx++;
         end
      end
   end

   task automatic model_load(input int sh);
      m_s = 32767;
      m_c = 0;
      m_k = (sh == 0) ? 1 : sh;
   endtask

   task automatic run_steps(input int n);
      for (int i = 0; i < n; i++) begin
         pair_t e;
         step_en = 1'b1;
         m_s = clip(m_s - (m_c >>> m_k));
         m_c = clip(m_c + (m_s >>> m_k));
         e.s = m_s;
         e.c = m_c;
         exp_q.push_back(e);
         @(negedge clk);
      end
      step_en = 1'b0;
      @(negedge clk);
      check(exp_q.size() == 0, "R5 all steps strobed", exp_q.size(), 0);
   endtask

   task automatic do_restart(input int sh, input bit with_step, input string req);
      restart   = 1'b1;
      step_en   = with_step;
      shift_amt = 4'(sh);
      @(negedge clk);
      restart = 1'b0;
      step_en = 1'b0;
      model_load(sh);
      check(int'(sin_out) == 32767, {req, " sine load"}, int'(sin_out), 32767);
      check(int'(cos_out) == 0, {req, " cosine load"}, int'(cos_out), 0);
      check(sample_vld == 1'b0, {req, " strobe low"}, int'(sample_vld), 0);
   endtask

   task automatic hold_cycles(input int n);
      int s0, c0;
      step_en = 1'b0;
      s0 = int'(sin_out);
      c0 = int'(cos_out);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check(int'(sin_out) == s0, "R6 sine held", int'(sin_out), s0);
         check(int'(cos_out) == c0, "R6 cosine held", int'(cos_out), c0);
         check(sample_vld == 1'b0, "R6 strobe low", int'(sample_vld), 0);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      // R1: reset state
      rst = 1'b1;
      shift_amt = 4'd1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      model_load(1);
      check(int'(sin_out) == 32767, "R1 reset sine", int'(sin_out), 32767);
      check(int'(cos_out) == 0, "R1 reset cosine", int'(cos_out), 0);
      check(sample_vld == 1'b0, "R1 reset strobe", int'(sample_vld), 0);

      // R4: k=1, third step saturates the cosine high
      run_steps(3);
      check(int'(cos_out) == 32767, "R4 positive saturation", int'(cos_out), 32767);
      check(int'(sin_out) == 10241, "R3 new-sine ordering", int'(sin_out), 10241);
      run_steps(20);

      // R6: idle hold
      hold_cycles(4);

      // R7: mid-run shift change ignored
      shift_amt = 4'd5;
      run_steps(10);
      shift_amt = 4'd1;

      // R8 and R9: restart with step_en high and shift 0
      do_restart(0, 1'b1, "R9");
      run_steps(1);
      check(int'(cos_out) == 16383, "R8 zero shift acts as one", int'(cos_out), 16383);
      run_steps(4);

      do_restart(3, 1'b0, "R1");
      run_steps(50);

      // R10: waveform period and peaks at k=6
      do_restart(6, 1'b0, "R1");
      meas_idx = 0; peak_hi = -40000; peak_lo = 40000;
      prev_s = 32767; x_first = -1; x_second = -1;
      meas_on = 1'b1;
      run_steps(1000);
      meas_on = 1'b0;
      check(peak_hi >= 31784, "R10 positive peak", peak_hi, 32767);
      check(peak_lo <= -31784, "R10 negative peak", peak_lo, -32767);
      check(x_first >= 0 && x_second > x_first, "R10 two crossings found", x_second, 1);
      check((x_second - x_first) >= 398 && (x_second - x_first) <= 406,
            "R10 period", x_second - x_first, 402);

      // k=15: both values stay at their load values
      do_restart(15, 1'b0, "R1");
      run_steps(5);
      check(int'(sin_out) == 32767, "R2 k=15 sine fixed", int'(sin_out), 32767);
      check(int'(cos_out) == 0, "R3 k=15 cosine fixed", int'(cos_out), 0);

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule